// File: doc/BRIEF.md
# Data-Polling Completion Checker

This block runs on the host side of a flash device once a program or erase command has been issued. A single-cycle `start` captures a polling address and the expected value of the device's completion bit. For erase polling the expected value is forced to 1. The checker then issues status reads on a simple synchronous read port and waits for the read-valid handshake of each one. It compares the completion bit (bit 7) of each returned word with the expected value, and it treats the timeout bit (bit 5) as the device's own failure indicator.

The two bits can change in the same device cycle, so a timeout indication never fails the operation at once. One further read of the completion bit decides the result. When the completion bit shows the true value, the rest of the word may still be stale. For that reason one extra read is made, and its full word is presented as the settled data. A parameterised cap on the number of status reads forces a fail, so a device that stops answering correctly cannot hold the checker forever. The result appears as a one-cycle `done` pulse with a `pass` flag that stays valid until the next start.

Top module: `flash_poll_checker`

## Requirements
- R1: While `rst` is high and after its release, `rd_req`, `done`, `pass` and `final_word` are all 0.
- R2: A `start` seen while idle latches `poll_addr`. Every read request is a one-cycle `rd_req` carrying that latched address, even if `poll_addr` changes later. A new request follows only after the previous one is answered.
- R3: The expected bit is 1 when `erase_mode` is high and `exp_poll_bit` otherwise. A status word whose bit 7 equals it counts as a match whatever its bit 5 holds, and a match leads to a pass.
- R4: A status word that mismatches on bit 7 and has bit 5 at 0 causes another status read, issued in the cycle after the word is accepted.
- R5: A status word that mismatches on bit 7 and has bit 5 at 1 causes exactly one recheck read. A matching bit 7 in the recheck leads to a pass, and a mismatch gives a fail.
- R6: After a match, one more read is made, and its whole word is shown on `final_word` when `done` rises. `final_word` is 0 after a failed run.
- R7: If `MAX_POLLS` status reads all mismatch with bit 5 at 0, the run ends in a fail with no further reads.
- R8: `done` is high for exactly one cycle, the cycle after the deciding `rd_valid`. `pass` clears in the cycle after an accepted `start` and otherwise changes only together with `done`.
- R9: `start` while a run is active, and `rd_valid` with no request outstanding (including the request cycle itself), are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| erase_mode | input | 1 | 1: erase polling, expected bit forced to 1 |
| exp_poll_bit | input | 1 | Bit 7 of the programmed datum |
| poll_addr | input | ADDR_W | Valid polling address |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid handshake |
| rd_data | input | DATA_W | Returned word |
| done | output | 1 | Result pulse |
| pass | output | 1 | 1: operation passed, held until next start |
| final_word | output | DATA_W | Settled data word after a pass |

## Verification
Every outcome is due exactly one clock after the `rd_valid` that decides it. That covers the next `rd_req` and the `done` pulse with `pass` and `final_word`. The clearing of `pass` is due one clock after an accepted `start`. The bench drives inputs and samples outputs on falling edges and numbers each falling edge of a run. It records the edge on which it presented the last response and demands `done` on the very next one, and it checks the request address on every request edge. Response latency varies from one to three cycles, so these checks run against several spacings of handshake.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PS_IDLE,
    PS_STATUS,
    PS_RECHECK,
    PS_FINAL
  } poll_state_t;

  typedef struct packed {
    logic match;
    logic tout;
  } poll_flags_t;
endpackage

// File: rtl/poll_eval.sv
module poll_eval #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOUT_BIT = 5
) (
  input  logic [DATA_W-1:0]     word,
  input  logic                  exp_bit,
  output poll_pkg::poll_flags_t flags
);
  always_comb begin
    flags.match = (word[POLL_BIT] == exp_bit);
    flags.tout  = word[TOUT_BIT];
  end
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
  parameter int unsigned MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(MAX_POLLS - 1));

  // the count never runs past the final allowed status read
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_POLLS - 1));
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  erase_mode,
  input  logic                  exp_poll_bit,
  input  logic [ADDR_W-1:0]     poll_addr,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  input  poll_pkg::poll_flags_t flags,
  input  logic                  lim_last,
  output logic                  exp_bit,
  output logic                  lim_clear,
  output logic                  lim_inc,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic                  done,
  output logic                  pass,
  output logic [DATA_W-1:0]     final_word
);
  import poll_pkg::*;

  poll_state_t state;
  logic        take;

  assign take      = rd_valid && !rd_req;
  assign lim_clear = (state == PS_IDLE) && start;
  assign lim_inc   = (state == PS_STATUS) && take && !flags.match && !flags.tout;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_IDLE;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      final_word <= '0;
      exp_bit    <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      case (state)
        PS_IDLE: begin
          if (start) begin
            rd_addr    <= poll_addr;
            exp_bit    <= erase_mode ? 1'b1 : exp_poll_bit;
            pass       <= 1'b0;
            final_word <= '0;
            rd_req     <= 1'b1;
            state      <= PS_STATUS;
          end
        end
        PS_STATUS: begin
          if (take) begin
            if (flags.match) begin
              rd_req <= 1'b1;
              state  <= PS_FINAL;
            end else if (flags.tout) begin
              rd_req <= 1'b1;
              state  <= PS_RECHECK;
            end else if (lim_last) begin
              done  <= 1'b1;
              pass  <= 1'b0;
              state <= PS_IDLE;
            end else begin
              rd_req <= 1'b1;
            end
          end
        end
        PS_RECHECK: begin
          if (take) begin
            if (flags.match) begin
              rd_req <= 1'b1;
              state  <= PS_FINAL;
            end else begin
              done  <= 1'b1;
              pass  <= 1'b0;
              state <= PS_IDLE;
            end
          end
        end
        PS_FINAL: begin
          if (take) begin
            final_word <= rd_data;
            done       <= 1'b1;
            pass       <= 1'b1;
            state      <= PS_IDLE;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state != PS_IDLE) |=> $stable(rd_addr));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_pass_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !(state == PS_IDLE && start) |=> (done || $stable(pass)));

  assert_req_not_done_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && done));
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned POLL_BIT  = 7,
  parameter int unsigned TOUT_BIT  = 5,
  parameter int unsigned MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              erase_mode,
  input  logic              exp_poll_bit,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              pass,
  output logic [DATA_W-1:0] final_word
);
  poll_pkg::poll_flags_t flags;
  logic exp_bit, lim_clear, lim_inc, lim_last;

  poll_eval #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOUT_BIT(TOUT_BIT)
  ) u_eval (
    .word(rd_data), .exp_bit(exp_bit), .flags(flags)
  );

  poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst(rst), .clear(lim_clear), .inc(lim_inc), .last(lim_last)
  );

  poll_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .erase_mode(erase_mode),
    .exp_poll_bit(exp_poll_bit), .poll_addr(poll_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .flags(flags),
    .lim_last(lim_last), .exp_bit(exp_bit), .lim_clear(lim_clear),
    .lim_inc(lim_inc), .rd_req(rd_req), .rd_addr(rd_addr), .done(done),
    .pass(pass), .final_word(final_word)
  );
endmodule

// File: tb/test_flash_poll_checker.sv
module test_flash_poll_checker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int MAXP = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, erase_mode = 1'b0;
  logic exp_poll_bit = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] rd_data = '0;
  logic rd_req, done, pass;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] final_word;

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_poll_checker #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) i_flash_poll_checker (
    .clk(clk), .rst(rst), .start(start), .erase_mode(erase_mode),
    .exp_poll_bit(exp_poll_bit), .poll_addr(poll_addr), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .pass(pass), .final_word(final_word)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind 0: match after k misses; 1: timeout then recheck match;
  // 2: timeout then recheck miss; 3: never match (limit)
  function automatic int exp_reads(input int kind, input int k);
    case (kind)
      0: return k + 2;
      1: return k + 3;
      2: return k + 2;
      default: return MAXP;
    endcase
  endfunction

  function automatic bit exp_pass(input int kind);
    return (kind == 0 || kind == 1);
  endfunction

  function automatic string kind_req(input int kind);
    case (kind)
      0: return "R3";
      1, 2: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [DW-1:0] make_word(input int kind, input int k, input bit e,
      input int idx, input logic [DW-1:0] fill, input logic [DW-1:0] fin);
    logic [DW-1:0] w = fill;
    if (kind == 3 || idx < k) begin
      w[7] = ~e; w[5] = 1'b0;
    end else if (idx == k) begin
      if (kind == 0) w[7] = e;
      else begin w[7] = ~e; w[5] = 1'b1; end
    end else if (idx == k + 1) begin
      if (kind == 0) w = fin;
      else if (kind == 1) w[7] = e;
      else w[7] = ~e;
    end else begin
      w = fin;
    end
    return w;
  endfunction

  task automatic run_op(input int kind, input int k, input bit erase, input bit ebit,
                        input logic [AW-1:0] addr, input bit mid_start);
    bit e = erase ? 1'b1 : ebit;
    bit pend = 0;
    logic [DW-1:0] fin = DW'($urandom);
    int reads = 0, lat = 0, cyc = 0, last_v = -10, done_cyc = -1;
    bit ep = exp_pass(kind);
    @(negedge clk);
    start = 1'b1; erase_mode = erase; exp_poll_bit = ebit; poll_addr = addr;
    @(negedge clk);
    start = 1'b0; erase_mode = ~erase; exp_poll_bit = ~ebit; poll_addr = ~addr;
    check(pass == 1'b0, "R8 pass cleared after start", 64'(pass), 64'd0);
    while (done_cyc < 0 && cyc < 400) begin
      rd_valid = 1'b0;
      if (mid_start) start = (cyc == 2);
      if (done) begin
        done_cyc = cyc;
      end else begin
        if (pend) begin
          if (lat == 0) begin
            rd_valid = 1'b1;
            rd_data = make_word(kind, k, e, reads - 1, DW'($urandom), fin);
            pend = 0;
            last_v = cyc;
          end else lat--;
        end
        if (rd_req) begin
          check(!pend, "R2 single outstanding request", 64'(pend), 64'd0);
          check(rd_addr == addr, "R2 latched read address", 64'(rd_addr), 64'(addr));
          pend = 1;
          lat = int'($urandom % 3);
          reads++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    rd_valid = 1'b0;
    check(done_cyc >= 0, "R8 done seen", 64'(done_cyc), 64'd0);
    check(done_cyc == last_v + 1, "R8 done one cycle after deciding rd_valid",
          64'(done_cyc), 64'(last_v + 1));
    check(reads == exp_reads(kind, k), $sformatf("%s/R4 read count", kind_req(kind)),
          64'(reads), 64'(exp_reads(kind, k)));
    check(pass == ep, $sformatf("%s result", kind_req(kind)), 64'(pass), 64'(ep));
    check(final_word == (ep ? fin : '0), "R6 settled word", 64'(final_word),
          64'(ep ? fin : '0));
    repeat (3) begin
      @(negedge clk);
      check(!done && !rd_req && pass == ep, "R8/R9 idle hold after done",
            {61'd0, done, rd_req, pass}, {63'd0, ep});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog (R2 handshake) actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] keep;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check(!rd_req && !done && !pass && final_word == '0, "R1 state in reset",
          {61'd0, rd_req, done, pass}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!rd_req && !done && !pass && final_word == '0, "R1 state after reset",
          {61'd0, rd_req, done, pass}, 64'd0);

    // stray handshake while idle
    rd_valid = 1'b1; rd_data = 16'h80a0;
    @(negedge clk); rd_valid = 1'b0;
    check(!rd_req && !done, "R9 stray rd_valid idle", {62'd0, rd_req, done}, 64'd0);

    run_op(0, 0, 1'b0, 1'b1, 24'h00_1234, 1'b0);
    keep = final_word;
    rd_valid = 1'b1; rd_data = 16'h0000;
    @(negedge clk); rd_valid = 1'b0;
    @(negedge clk);
    check(!done && !rd_req && pass && final_word == keep, "R9 stray rd_valid after pass",
          64'(final_word), 64'(keep));

    run_op(0, 0, 1'b1, 1'b0, 24'h3f_0000, 1'b0);   // R3 erase forces expected 1
    run_op(0, 3, 1'b0, 1'b0, 24'h00_0abc, 1'b0);   // R4 misses then match
    run_op(1, 2, 1'b0, 1'b1, 24'h12_3456, 1'b0);   // R5 recheck rescues
    run_op(2, 1, 1'b1, 1'b1, 24'h7f_ffff, 1'b0);   // R5 recheck fails
    run_op(3, 0, 1'b0, 1'b1, 24'h00_0001, 1'b0);   // R7 limit
    run_op(1, 0, 1'b1, 1'b0, 24'h55_aa55, 1'b0);   // R5 timeout on first read
    run_op(0, MAXP - 1, 1'b0, 1'b1, 24'h0f_0f0f, 1'b0); // R7 one below limit
    run_op(0, 4, 1'b0, 1'b0, 24'h24_6800, 1'b1);   // R9 start while busy

    for (int i = 0; i < 24; i++) begin
      int kind = int'($urandom % 4);
      int k = int'($urandom % MAXP);
      run_op(kind, k, bit'($urandom % 2), bit'($urandom % 2), AW'($urandom), 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule